// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block turns one digital duty command into as many as four pulse-width-modulated phase drives. The drives are spread evenly across the switching period. A free-running period counter acts as the shared sawtooth. Each present channel takes a slot, in index order, and its pulse starts at its own offset into the period. The number of present channels sets the spacing, so the combined ripple seen by the load runs at the per-channel rate times the active count.

Each channel also has a digitised current sample. The sample is captured once per period at a fixed point of that channel's own cycle and held until the next capture. The block averages the held samples of the present channels. It shortens the pulse of a channel that carries more than the average and lengthens the pulse of one that carries less, so the phases share the load. The average is also compared with a trip level derived from the nominal full-load sample, and an over-current flag is raised when the average goes above it.

Every drive is coded on two wires: a high-impedance bit and a level bit. Reset, a low enable, or a request for high impedance puts all drives into the high-impedance state rather than driving them low.

Top module: `interleaved_pwm`

## Requirements
- R1: With settled inputs, a present channel's output is high for exactly its trimmed duty, in clock cycles, within every window of PERIOD = 2^CNT_W consecutive cycles, and low for the rest of the window.
- R2: Bit k of `chanUsed` set to 1 marks channel k present. The active count n is the number of set bits, and a present channel's slot rank is the number of present channels with a lower index.
- R3: A present channel of rank r starts its pulse r * floor(PERIOD / n) cycles after the rank-0 channel starts its pulse.
- R4: Over one period, the total number of rising edges across all outputs equals the number of present channels whose trimmed duty lies strictly between 0 and PERIOD. The ripple rate is therefore n times the per-channel rate.
- R5: The trimmed duty equals dutyCmd + floor((avg - s) / 2^TRIM_SHIFT). Here s is the channel's held sample and avg = floor(sum of the held samples of present channels / n). A channel above the average gets a shorter pulse; one below it gets a longer pulse.
- R6: The trimmed duty is clamped to the range 0 to PERIOD. A clamped-high channel stays high for the whole period, and a clamped-low channel never goes high.
- R7: An absent channel drives high impedance (`pwmHiZ` bit = 1, `pwmHigh` bit = 0). Its current sample affects neither the duties of the other channels nor the over-current flag.
- R8: When reset is asserted, all drives are high impedance at once. When `enable` is low or `hiZReq` is high, all drives are high impedance with the level bit 0 after the next clock edge.
- R9: `ocFlag` is 1 exactly when avg is strictly greater than floor(NOM_FULL * 165 / 100). With the default NOM_FULL = 400 the trip level is 660. The flag is 0 when no channel is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = drive outputs, 0 = all high impedance |
| hiZReq | input | 1 | 1 = force all outputs to high impedance |
| chanUsed | input | 4 | Channel present mask, bit k for channel k |
| dutyCmd | input | CNT_W+1 | Shared duty command in cycles per period (0 to PERIOD) |
| curSample | input | 4*CUR_W | Per-channel current samples, channel k in bits [k*CUR_W +: CUR_W] |
| pwmHigh | output | 4 | Level bit per channel, 1 = high, 0 = low |
| pwmHiZ | output | 4 | 1 = channel drive is high impedance |
| ocFlag | output | 1 | Average channel current is above the trip level |

## Verification
A wrong slot rank or offset does not change the pulse widths. It shows only in the spacing between rising edges of different channels, and that spacing is visible within one period after the inputs settle. A bad average or a sign error in the trim changes every channel's high-cycle count by the same correction, with opposite signs for channels above and below the mean. The change appears two periods after a new sample pattern: one period to capture the sample and one to load the duty. A failure to exclude an absent channel shows up both in the duties of the present channels and in the over-current flag, so the bench places a large sample on absent lanes and checks both.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int PWM_LANES = 4;
  localparam int LANE_CNT_W = $clog2(PWM_LANES + 1);

  // Per-lane strobes from the control to the datapath.
  typedef struct packed {
    logic [PWM_LANES-1:0] loadStb;    // lane local count is zero
    logic [PWM_LANES-1:0] sampleStb;  // lane local count is at the sample point
    logic                 driveEn;    // outputs may be driven
  } pwmStrobe_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SAMPLE_PT = 192
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                enable,
  input  logic                                hiZReq,
  input  logic [PWM_LANES-1:0]                chanUsed,
  output logic [LANE_CNT_W-1:0]               activeN,
  output logic [PWM_LANES-1:0][CNT_W-1:0]     localCnt,
  output pwmStrobe_t                          strobes
);
  localparam int PERIOD = 1 << CNT_W;
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_PT);

  logic [CNT_W-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periodCnt <= '0;
    else       periodCnt <= periodCnt + 1'b1;
  end

  always_comb begin
    activeN = '0;
    for (int k = 0; k < PWM_LANES; k++)
      activeN = activeN + LANE_CNT_W'(chanUsed[k]);
  end

  function automatic logic [CNT_W-1:0] slotOffset(input logic [LANE_CNT_W-1:0] rank,
                                                  input logic [LANE_CNT_W-1:0] n);
    int step;
    case (n)
      LANE_CNT_W'(2): step = PERIOD / 2;
      LANE_CNT_W'(3): step = PERIOD / 3;
      LANE_CNT_W'(4): step = PERIOD / 4;
      default:        step = 0;
    endcase
    return CNT_W'(int'(rank) * step);
  endfunction

  for (genvar k = 0; k < PWM_LANES; k++) begin : g_lane
    logic [LANE_CNT_W-1:0] laneRank;
    logic [CNT_W-1:0]      laneOffset;

    always_comb begin
      laneRank = '0;
      for (int j = 0; j < k; j++)
        laneRank = laneRank + LANE_CNT_W'(chanUsed[j]);
    end

    assign laneOffset           = slotOffset(laneRank, activeN);
    assign localCnt[k]          = periodCnt - laneOffset;
    assign strobes.loadStb[k]   = (localCnt[k] == '0);
    assign strobes.sampleStb[k] = (localCnt[k] == SAMPLE_AT);
  end

  assign strobes.driveEn = enable & ~hiZReq;
endmodule

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CUR_W      = 10,
  parameter int TRIM_SHIFT = 2,
  parameter int NOM_FULL   = 400
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pwmStrobe_t                      strobes,
  input  logic [PWM_LANES-1:0]            chanUsed,
  input  logic [LANE_CNT_W-1:0]           activeN,
  input  logic [PWM_LANES-1:0][CNT_W-1:0] localCnt,
  input  logic [CNT_W:0]                  dutyCmd,
  input  logic [PWM_LANES*CUR_W-1:0]      curSample,
  output logic [PWM_LANES-1:0]            pwmHigh,
  output logic [PWM_LANES-1:0]            pwmHiZ,
  output logic                            ocFlag
);
  localparam int PERIOD   = 1 << CNT_W;
  localparam int DUTY_W   = CNT_W + 1;
  localparam int SUM_W    = CUR_W + $clog2(PWM_LANES + 1);
  localparam int RAW_W    = ((SUM_W > DUTY_W) ? SUM_W : DUTY_W) + 2;
  localparam int OC_LIMIT = (NOM_FULL * 165) / 100;
  localparam logic signed [RAW_W-1:0] PERIOD_S = RAW_W'(PERIOD);
  localparam logic [SUM_W-1:0] OC_LIMIT_V = SUM_W'(OC_LIMIT);

  logic [PWM_LANES-1:0][CUR_W-1:0] heldSample;
  logic [SUM_W-1:0]                sampleSum;
  logic [SUM_W-1:0]                avgCur;

  // Sum of present lanes only.
  always_comb begin
    sampleSum = '0;
    for (int k = 0; k < PWM_LANES; k++)
      if (chanUsed[k]) sampleSum = sampleSum + SUM_W'(heldSample[k]);
  end

  // Divide by the active count; the only odd divisor is a constant three.
  always_comb begin
    case (activeN)
      LANE_CNT_W'(1): avgCur = sampleSum;
      LANE_CNT_W'(2): avgCur = sampleSum >> 1;
      LANE_CNT_W'(3): avgCur = sampleSum / SUM_W'(3);
      LANE_CNT_W'(4): avgCur = sampleSum >> 2;
      default:        avgCur = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocFlag <= 1'b0;
    else       ocFlag <= (avgCur > OC_LIMIT_V);
  end

  for (genvar k = 0; k < PWM_LANES; k++) begin : g_lane
    logic signed [RAW_W-1:0] devVal;
    logic signed [RAW_W-1:0] trimCorr;
    logic signed [RAW_W-1:0] rawDuty;
    logic [DUTY_W-1:0]       trimDuty;
    logic [DUTY_W-1:0]       dutyReg;
    logic [DUTY_W-1:0]       dutyAct;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     heldSample[k] <= '0;
      else if (strobes.sampleStb[k]) heldSample[k] <= curSample[k*CUR_W +: CUR_W];
    end

    always_comb begin
      devVal   = $signed(RAW_W'(avgCur)) - $signed(RAW_W'(heldSample[k]));
      trimCorr = devVal >>> TRIM_SHIFT;
      rawDuty  = $signed(RAW_W'(dutyCmd)) + trimCorr;
      if (rawDuty < 0)             trimDuty = '0;
      else if (rawDuty > PERIOD_S) trimDuty = DUTY_W'(PERIOD);
      else                         trimDuty = rawDuty[DUTY_W-1:0];
    end

    // A new duty takes effect only at the start of the lane's own period.
    assign dutyAct = strobes.loadStb[k] ? trimDuty : dutyReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyReg    <= '0;
        pwmHigh[k] <= 1'b0;
        pwmHiZ[k]  <= 1'b1;
      end else begin
        dutyReg    <= dutyAct;
        pwmHiZ[k]  <= ~(strobes.driveEn & chanUsed[k]);
        pwmHigh[k] <= strobes.driveEn & chanUsed[k] &
                      ({1'b0, localCnt[k]} < dutyAct);
      end
    end
  end
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm
  import mpwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CUR_W      = 10,
  parameter int TRIM_SHIFT = 2,
  parameter int NOM_FULL   = 400,
  parameter int SAMPLE_PT  = ((1 << CNT_W) * 3) / 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       hiZReq,
  input  logic [PWM_LANES-1:0]       chanUsed,
  input  logic [CNT_W:0]             dutyCmd,
  input  logic [PWM_LANES*CUR_W-1:0] curSample,
  output logic [PWM_LANES-1:0]       pwmHigh,
  output logic [PWM_LANES-1:0]       pwmHiZ,
  output logic                       ocFlag
);
  pwmStrobe_t                      strobes;
  logic [LANE_CNT_W-1:0]           activeN;
  logic [PWM_LANES-1:0][CNT_W-1:0] localCnt;

  mpwm_ctrl #(.CNT_W(CNT_W), .SAMPLE_PT(SAMPLE_PT)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .hiZReq(hiZReq),
    .chanUsed(chanUsed), .activeN(activeN), .localCnt(localCnt),
    .strobes(strobes)
  );

  mpwm_datapath #(.CNT_W(CNT_W), .CUR_W(CUR_W), .TRIM_SHIFT(TRIM_SHIFT),
                  .NOM_FULL(NOM_FULL)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chanUsed(chanUsed),
    .activeN(activeN), .localCnt(localCnt), .dutyCmd(dutyCmd),
    .curSample(curSample), .pwmHigh(pwmHigh), .pwmHiZ(pwmHiZ),
    .ocFlag(ocFlag)
  );
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
  import mpwm_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 enable,
  input logic                 hiZReq,
  input logic [PWM_LANES-1:0] chanUsed,
  input logic [PWM_LANES-1:0] pwmHigh,
  input logic [PWM_LANES-1:0] pwmHiZ,
  input logic                 ocFlag
);
  AST_OFF_ALL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || hiZReq) |=> ((&pwmHiZ) && (pwmHigh == '0))); // R8

  AST_ABSENT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~$past(chanUsed) & ~pwmHiZ) == '0)); // R7

  AST_ONE_RISE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && $past(enable, 2) && !$past(hiZReq) && !$past(hiZReq, 2) &&
     ($past(chanUsed) == $past(chanUsed, 2)))
    |-> $onehot0(pwmHigh & ~$past(pwmHigh))); // R3

  AST_NO_OC_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chanUsed) == '0) |-> !ocFlag); // R9
endmodule

bind interleaved_pwm mpwm_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .hiZReq(hiZReq),
  .chanUsed(chanUsed), .pwmHigh(pwmHigh), .pwmHiZ(pwmHiZ), .ocFlag(ocFlag)
);

// File: tb/interleaved_pwm_tb.sv
module interleaved_pwm_tb;
  localparam int CNT_W  = 8;
  localparam int CUR_W  = 10;
  localparam int PERIOD = 1 << CNT_W;
  localparam int LANES  = 4;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   enable = 1'b0;
  logic                   hiZReq = 1'b0;
  logic [LANES-1:0]       chanUsed = '0;
  logic [CNT_W:0]         dutyCmd = '0;
  logic [LANES*CUR_W-1:0] curSample = '0;
  logic [LANES-1:0]       pwmHigh, pwmHiZ;
  logic                   ocFlag;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  interleaved_pwm u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .hiZReq(hiZReq),
    .chanUsed(chanUsed), .dutyCmd(dutyCmd), .curSample(curSample),
    .pwmHigh(pwmHigh), .pwmHiZ(pwmHiZ), .ocFlag(ocFlag)
  );

  // kind 0: high-cycle count, 1: phase distance to refCh, 2: total rising edges
  typedef struct {
    int    kind;
    int    ch;
    int    refCh;
    int    value;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int hiCnt[LANES];
  int riseAt[LANES];
  int totalRise;

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: apply a pattern and push the expected results derived from the requirements.
  task automatic applyPattern(input logic [LANES-1:0] mask, input int duty,
                              input int s0, input int s1, input int s2, input int s3,
                              input string req);
    int smp[LANES];
    int n, sum, avg, rank0Ch, edges;
    int rank[LANES];
    int dExp[LANES];
    expItem_t it;
    smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
    @(negedge clk);
    chanUsed = mask;
    dutyCmd  = (CNT_W+1)'(duty);
    for (int k = 0; k < LANES; k++) curSample[k*CUR_W +: CUR_W] = CUR_W'(smp[k]);
    n = 0; sum = 0; rank0Ch = -1; edges = 0;
    for (int k = 0; k < LANES; k++)
      if (mask[k]) begin
        rank[k] = n; n++; sum += smp[k];
        if (rank0Ch < 0) rank0Ch = k;
      end
    avg = (n > 0) ? sum / n : 0;
    for (int k = 0; k < LANES; k++) begin
      if (mask[k]) begin
        int raw;
        raw = duty + ((avg - smp[k]) >>> 2);      // R5 trim
        if (raw < 0) raw = 0;                     // R6 clamp
        if (raw > PERIOD) raw = PERIOD;
        dExp[k] = raw;
        if (raw > 0 && raw < PERIOD) edges++;
      end else dExp[k] = 0;                       // R7 absent lane never high
      it = '{0, k, 0, dExp[k], req};
      expQ.push_back(it);
    end
    for (int k = 0; k < LANES; k++)
      if (mask[k] && k != rank0Ch && dExp[k] > 0 && dExp[k] < PERIOD &&
          dExp[rank0Ch] > 0 && dExp[rank0Ch] < PERIOD) begin
        it = '{1, k, rank0Ch, rank[k] * (PERIOD / n), "R3"};
        expQ.push_back(it);
      end
    it = '{2, 0, 0, edges, "R4"};
    expQ.push_back(it);
    repeat (3 * PERIOD + 8) @(negedge clk);
  endtask

  // Monitor: observe one period and compare against the queued items.
  task automatic measureAndCompare();
    logic [LANES-1:0] prev;
    expItem_t it;
    totalRise = 0;
    for (int k = 0; k < LANES; k++) begin hiCnt[k] = 0; riseAt[k] = -1; end
    prev = pwmHigh;
    for (int t = 0; t < PERIOD; t++) begin
      @(negedge clk);
      for (int k = 0; k < LANES; k++) begin
        if (pwmHigh[k] && !pwmHiZ[k]) hiCnt[k]++;
        if (pwmHigh[k] && !prev[k]) begin
          totalRise++;
          if (riseAt[k] < 0) riseAt[k] = t;
        end
      end
      prev = pwmHigh;
    end
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      case (it.kind)
        0: checkVal(it.req, $sformatf("ch%0d high cycles (R1)", it.ch), hiCnt[it.ch], it.value);
        1: checkVal(it.req, $sformatf("ch%0d phase vs ch%0d (R2)", it.ch, it.refCh),
                    (riseAt[it.ch] - riseAt[it.refCh] + PERIOD) % PERIOD, it.value);
        default: checkVal(it.req, "rising edges per period", totalRise, it.value);
      endcase
    end
  endtask

  task automatic checkHiZ(input logic [LANES-1:0] expHiZ, input string req);
    checkVal(req, "pwmHiZ", int'(pwmHiZ), int'(expHiZ));
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    checkHiZ(4'b1111, "R8");
    checkVal("R8", "pwmHigh in reset", int'(pwmHigh), 0);
    checkVal("R9", "ocFlag in reset", int'(ocFlag), 0);
    rstN = 1'b1; enable = 1'b1;

    // R1 R3 R4: four balanced lanes
    applyPattern(4'b1111, 100, 400, 400, 400, 400, "R1");
    measureAndCompare();
    checkVal("R9", "ocFlag at avg 400", int'(ocFlag), 0);

    // R5: imbalance, above-average lane shorter
    applyPattern(4'b1111, 100, 480, 320, 400, 400, "R5");
    measureAndCompare();

    // R2 R5 R7: three lanes, absent lane with a large sample
    applyPattern(4'b0111, 128, 300, 330, 360, 1000, "R5");
    measureAndCompare();
    checkHiZ(4'b1000, "R7");

    // R6: clamp low on lane 2
    applyPattern(4'b0101, 10, 100, 0, 500, 0, "R6");
    measureAndCompare();

    // R6: clamp high on lane 0
    applyPattern(4'b0011, 250, 0, 400, 0, 0, "R6");
    measureAndCompare();

    // R2 R3: two lanes at odd positions
    applyPattern(4'b1010, 60, 0, 200, 0, 200, "R2");
    measureAndCompare();
    checkHiZ(4'b0101, "R7");

    // R9: trip boundary
    applyPattern(4'b1111, 100, 660, 660, 660, 660, "R1");
    measureAndCompare();
    checkVal("R9", "ocFlag at avg 660", int'(ocFlag), 0);
    applyPattern(4'b1111, 100, 661, 660, 660, 660, "R1");
    measureAndCompare();
    checkVal("R9", "ocFlag at avg 660 (floor)", int'(ocFlag), 0);
    applyPattern(4'b1111, 100, 661, 661, 661, 661, "R1");
    measureAndCompare();
    checkVal("R9", "ocFlag at avg 661", int'(ocFlag), 1);

    // R7: absent lanes carry big samples, flag stays low
    applyPattern(4'b0011, 100, 600, 600, 1023, 1023, "R7");
    measureAndCompare();
    checkVal("R7", "ocFlag with absent lanes high", int'(ocFlag), 0);

    // R8: disable and high-impedance request, one edge latency
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    checkHiZ(4'b1111, "R8");
    checkVal("R8", "pwmHigh when disabled", int'(pwmHigh), 0);
    enable = 1'b1; hiZReq = 1'b1;
    @(negedge clk);
    checkHiZ(4'b1111, "R8");
    checkVal("R8", "pwmHigh on hiZReq", int'(pwmHigh), 0);
    hiZReq = 1'b0;
    @(negedge clk);
    checkHiZ(4'b1100, "R8");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule